// File: doc/BRIEF.md
# Configuration Register Space with Base-Address Sizing

This block holds the 256-byte configuration space of one function on a shared peripheral bus. A host reads it and writes it with byte addresses and an access width of one, two or four bytes. Identity fields (vendor, device, revision, class, header type, interrupt pin) come from parameters and cannot be written. A small set of bytes is writable: command, cache line, latency, interrupt line, and the device-specific area.

Six base address registers start at offset 0x10, and an expansion ROM base register sits at 0x30. A full-word write to one of them is masked to the size of its region. Software therefore writes all ones, reads the value back and learns the region size. The low bits hold a fixed type code. When a write touches the command register or a base register, the block raises a one-cycle remap request so that downstream logic can rebuild its address windows.

Top module: `cfgspc_regfile`

## Requirements
- R1: After reset the command register, the interrupt line and every base register address field read as zero. The device-specific bytes 0x40 to 0xFF also read as zero. Only the fixed type bits remain in the base registers.
- R2: Reads are combinational and little-endian, with the lowest address byte in bits 7:0. Width code 2'b10 returns four bytes when the offset is at most 0xFC. Code 2'b01 returns two bytes when the offset is at most 0xFE. Every other case returns one byte, zero-extended, and this includes code 2'b11.
- R3: The identity bytes read their parameter values and ignore writes. These are vendor at 0x00–0x01, device at 0x02–0x03, revision at 0x08, class at 0x09–0x0B, header type at 0x0E and interrupt pin at 0x3D.
- R4: A word write with an offset in 0x10–0x27 loads base register n = (offset−0x10)/4 with the data ANDed with ~(size−1). The register reads back that value ORed with its type bits: 1 for an I/O region and 0 for a memory region.
- R5: A base register with a region size of zero reads as zero whatever is written to it.
- R6: A word write with an offset in 0x30–0x33 loads the ROM base with the data ANDed with (~(size−1) | 1), so bit 0 survives as the ROM enable.
- R7: Writes to base or ROM bytes that are not word wide change nothing.
- R8: All other writes are applied byte by byte from the offset upward, taking byte k from data bits 8k+7:8k. Only 0x04–0x05, 0x0C–0x0D, 0x3C and 0x40–0xFF store data. Every other byte ignores writes, and bytes past 0xFF are dropped.
- R9: remap_o is high for exactly the cycle after a write whose bytes overlap 0x04–0x05, or after a word write to a base or ROM register. It is low after any other cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Write strobe, taken at the rising edge |
| addr_i | input | 8 | Byte offset of the access |
| width_i | input | 2 | 00 byte, 01 half, 10 word, 11 byte |
| wdata_i | input | 32 | Write data, byte k for offset+k |
| rdata_o | output | 32 | Read data for addr_i and width_i |
| remap_o | output | 1 | Mapping update request, one cycle |

## Verification
A wrong base register shows up on the first read-back after a sizing write: the low address bits fail to clear, or the type bit is missing. Since reads are combinational, this is visible in the same cycle that follows the write edge. A faulty writable-byte map or byte lane shows up on the next read of the neighbouring offsets, because a dropped or misplaced byte sits at a known position in rdata_o. A fault in the remap decode appears on remap_o one edge after the offending write.

// File: rtl/cfgspc_pkg.sv
package cfgspc_pkg;
  localparam int SPACE_BYTES = 256;
  localparam int ADDR_W      = 8;
  localparam int NUM_BAR     = 6;
  localparam int NUM_SLOT    = NUM_BAR + 1;
  localparam int ROM_SLOT    = NUM_BAR;
  localparam int SLOT_W      = $clog2(NUM_SLOT);

  localparam logic [ADDR_W-1:0] BAR_FIRST = 8'h10;
  localparam logic [ADDR_W-1:0] BAR_END   = 8'h28;
  localparam logic [ADDR_W-1:0] ROM_FIRST = 8'h30;
  localparam logic [ADDR_W-1:0] ROM_END   = 8'h34;
  localparam logic [ADDR_W-1:0] CMD_LO    = 8'h04;
  localparam logic [ADDR_W-1:0] CMD_HI    = 8'h05;

  typedef enum logic [1:0] {
    W_BYTE = 2'b00,
    W_HALF = 2'b01,
    W_WORD = 2'b10,
    W_ALT  = 2'b11
  } width_e;

  function automatic logic byte_writable(input int a);
    return (a == 4) || (a == 5) || (a == 12) || (a == 13) || (a == 60) || (a >= 64);
  endfunction

  function automatic logic [2:0] write_len(input logic [1:0] w);
    case (width_e'(w))
      W_HALF:  return 3'd2;
      W_WORD:  return 3'd4;
      default: return 3'd1;
    endcase
  endfunction
endpackage

// File: rtl/cfgspc_byte_store.sv
module cfgspc_byte_store
  import cfgspc_pkg::*;
(
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         wr_en_i,
  input  logic [ADDR_W-1:0]            addr_i,
  input  logic [2:0]                   len_i,
  input  logic [31:0]                  wdata_i,
  output logic [SPACE_BYTES-1:0][7:0]  bytes_o
);
  for (genvar i = 0; i < SPACE_BYTES; i++) begin : g_byte
    if (byte_writable(i)) begin : g_rw
      logic [ADDR_W:0] off;
      logic            hit;
      logic [7:0]      wb;
      logic [7:0]      q;
      assign off = (ADDR_W+1)'(i) - {1'b0, addr_i};
      assign hit = wr_en_i && ({1'b0, addr_i} <= (ADDR_W+1)'(i))
                   && (off < (ADDR_W+1)'(len_i));
      always_comb begin
        case (off[1:0])
          2'd0:    wb = wdata_i[7:0];
          2'd1:    wb = wdata_i[15:8];
          2'd2:    wb = wdata_i[23:16];
          default: wb = wdata_i[31:24];
        endcase
      end
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)  q <= '0;
        else if (hit) q <= wb;
      end
      assign bytes_o[i] = q;
    end else begin : g_ro
      assign bytes_o[i] = '0;
    end
  end
endmodule

// File: rtl/cfgspc_bar_bank.sv
module cfgspc_bar_bank
  import cfgspc_pkg::*;
#(
  parameter logic [NUM_BAR-1:0][31:0] BAR_SIZE  = '0,
  parameter logic [NUM_BAR-1:0]       BAR_IS_IO = '0,
  parameter logic [31:0]              ROM_SIZE  = '0
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       wr_i,
  input  logic [SLOT_W-1:0]          slot_i,
  input  logic [31:0]                wdata_i,
  output logic [NUM_SLOT-1:0][31:0]  val_o
);
  for (genvar s = 0; s < NUM_SLOT; s++) begin : g_slot
    if (s < NUM_BAR) begin : g_bar
      localparam logic [31:0] SZ = BAR_SIZE[s];
      if (SZ == 0) begin : g_off
        assign val_o[s] = '0;
      end else begin : g_on
        localparam logic [31:0] KEEP = ~(SZ - 32'd1);
        localparam logic [31:0] TYP  = BAR_IS_IO[s] ? 32'd1 : 32'd0;
        logic [31:0] q;
        always_ff @(posedge clk_i or negedge rst_ni) begin
          if (!rst_ni)                               q <= '0;
          else if (wr_i && slot_i == SLOT_W'(s))     q <= wdata_i & KEEP;
        end
        assign val_o[s] = q | TYP;
      end
    end else begin : g_rom
      if (ROM_SIZE == 0) begin : g_off
        assign val_o[s] = '0;
      end else begin : g_on
        localparam logic [31:0] KEEP = ~(ROM_SIZE - 32'd1) | 32'd1;
        logic [31:0] q;
        always_ff @(posedge clk_i or negedge rst_ni) begin
          if (!rst_ni)                               q <= '0;
          else if (wr_i && slot_i == SLOT_W'(s))     q <= wdata_i & KEEP;
        end
        assign val_o[s] = q;
      end
    end
  end
endmodule

// File: rtl/cfgspc_regfile.sv
module cfgspc_regfile
  import cfgspc_pkg::*;
#(
  parameter logic [15:0]              VENDOR_ID   = 16'h1b36,
  parameter logic [15:0]              DEVICE_ID   = 16'h0005,
  parameter logic [7:0]               REVISION    = 8'h01,
  parameter logic [23:0]              CLASS_CODE  = 24'h020000,
  parameter logic [7:0]               HEADER_TYPE = 8'h00,
  parameter logic [7:0]               INT_PIN     = 8'h01,
  parameter logic [NUM_BAR-1:0][31:0] BAR_SIZE    = {32'h0, 32'h0, 32'h0, 32'h0,
                                                     32'h100, 32'h20},
  parameter logic [NUM_BAR-1:0]       BAR_IS_IO   = 6'b000001,
  parameter logic [31:0]              ROM_SIZE    = 32'h800
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [1:0]        width_i,
  input  logic [31:0]       wdata_i,
  output logic [31:0]       rdata_o,
  output logic              remap_o
);
  logic                        is_word;
  logic                        bar_hit;
  logic [SLOT_W-1:0]           slot;
  logic [2:0]                  wlen;
  logic [ADDR_W:0]             wend;
  logic                        cmd_touch;
  logic [NUM_SLOT-1:0][31:0]   bar_val;
  logic [SPACE_BYTES-1:0][7:0] store;
  logic [SPACE_BYTES-1:0][7:0] view;

  assign is_word = (width_e'(width_i) == W_WORD);
  assign bar_hit = is_word && (((addr_i >= BAR_FIRST) && (addr_i < BAR_END)) ||
                               ((addr_i >= ROM_FIRST) && (addr_i < ROM_END)));
  always_comb begin
    if (addr_i >= ROM_FIRST) slot = SLOT_W'(ROM_SLOT);
    else                     slot = SLOT_W'((addr_i - BAR_FIRST) >> 2);
  end

  assign wlen      = write_len(width_i);
  assign wend      = {1'b0, addr_i} + (ADDR_W+1)'(wlen);
  assign cmd_touch = (addr_i <= CMD_HI) && (wend > (ADDR_W+1)'(CMD_LO));

  cfgspc_bar_bank #(
    .BAR_SIZE  (BAR_SIZE),
    .BAR_IS_IO (BAR_IS_IO),
    .ROM_SIZE  (ROM_SIZE)
  ) u_bars (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_i    (wr_en_i && bar_hit),
    .slot_i  (slot),
    .wdata_i (wdata_i),
    .val_o   (bar_val)
  );

  cfgspc_byte_store u_store (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_en_i (wr_en_i && !bar_hit),
    .addr_i  (addr_i),
    .len_i   (wlen),
    .wdata_i (wdata_i),
    .bytes_o (store)
  );

  // per-offset readable view: constants, base registers, then stored bytes
  for (genvar i = 0; i < SPACE_BYTES; i++) begin : g_view
    if (i < 2) begin : g_ven
      assign view[i] = VENDOR_ID[8*i +: 8];
    end else if (i < 4) begin : g_dev
      assign view[i] = DEVICE_ID[8*(i-2) +: 8];
    end else if (i == 8) begin : g_rev
      assign view[i] = REVISION;
    end else if (i >= 9 && i < 12) begin : g_cls
      assign view[i] = CLASS_CODE[8*(i-9) +: 8];
    end else if (i == 14) begin : g_hdr
      assign view[i] = HEADER_TYPE;
    end else if (i == 61) begin : g_pin
      assign view[i] = INT_PIN;
    end else if (i >= 16 && i < 40) begin : g_bar
      assign view[i] = bar_val[(i-16)/4][8*(i%4) +: 8];
    end else if (i >= 48 && i < 52) begin : g_rom
      assign view[i] = bar_val[ROM_SLOT][8*(i%4) +: 8];
    end else begin : g_mem
      assign view[i] = store[i];
    end
  end

  logic [ADDR_W-1:0] a1, a2, a3;
  assign a1 = addr_i + 8'd1;
  assign a2 = addr_i + 8'd2;
  assign a3 = addr_i + 8'd3;

  always_comb begin
    rdata_o = {24'd0, view[addr_i]};
    if (is_word && addr_i <= 8'hFC)
      rdata_o = {view[a3], view[a2], view[a1], view[addr_i]};
    else if (width_e'(width_i) == W_HALF && addr_i <= 8'hFE)
      rdata_o = {16'd0, view[a1], view[addr_i]};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) remap_o <= 1'b0;
    else         remap_o <= wr_en_i && (bar_hit || cmd_touch);
  end
endmodule

// File: rtl/cfgspc_regfile_chk.sv
module cfgspc_regfile_chk
  import cfgspc_pkg::*;
#(
  parameter logic [15:0]              VENDOR_ID = 16'h0,
  parameter logic [15:0]              DEVICE_ID = 16'h0,
  parameter logic [NUM_BAR-1:0][31:0] BAR_SIZE  = '0,
  parameter logic [NUM_BAR-1:0]       BAR_IS_IO = '0,
  parameter logic [31:0]              ROM_SIZE  = '0
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              wr_en_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [1:0]        width_i,
  input logic [31:0]       wdata_i,
  input logic [31:0]       rdata_o,
  input logic              remap_o
);
  localparam logic [31:0] B0_LOW = BAR_SIZE[0] - 32'd1;
  localparam logic [31:0] B0_TYP = BAR_IS_IO[0] ? 32'd1 : 32'd0;
  localparam logic [31:0] RM_LOW = (ROM_SIZE - 32'd1) & ~32'd1;

  p_cmd_remap_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && width_i == 2'b00 && addr_i == CMD_LO) |=> remap_o);

  p_idle_quiet_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_i |=> !remap_o);

  p_byte_zext_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (width_i == 2'b00) |-> (rdata_o[31:8] == 24'd0));

  p_ident_fixed_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i == 8'h00 && width_i == 2'b10) |-> (rdata_o == {DEVICE_ID, VENDOR_ID}));

  p_bar0_aligned_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (BAR_SIZE[0] != 0 && addr_i == BAR_FIRST && width_i == 2'b10)
      |-> ((rdata_o & B0_LOW) == B0_TYP));

  p_rom_aligned_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ROM_SIZE != 0 && addr_i == ROM_FIRST && width_i == 2'b10)
      |-> ((rdata_o & RM_LOW) == 32'd0));
endmodule

bind cfgspc_regfile cfgspc_regfile_chk #(
  .VENDOR_ID (VENDOR_ID),
  .DEVICE_ID (DEVICE_ID),
  .BAR_SIZE  (BAR_SIZE),
  .BAR_IS_IO (BAR_IS_IO),
  .ROM_SIZE  (ROM_SIZE)
) u_chk (.*);

// File: tb/cfgspc_regfile_test.sv
module cfgspc_regfile_test;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        wr_en_i = 1'b0;
  logic [7:0]  addr_i = '0;
  logic [1:0]  width_i = '0;
  logic [31:0] wdata_i = '0;
  logic [31:0] rdata_o;
  logic        remap_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  cfgspc_regfile uut (.*);

  always #4 clk_i = ~clk_i;

  typedef struct packed {
    logic        wr;
    logic [7:0]  addr;
    logic [1:0]  w;
    logic [31:0] wd;
    logic [31:0] exp;
    logic        rmp;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 34;
  localparam vec_t VEC [NV] = '{
    '{1'b0, 8'h00, 2'b10, 32'h0,        32'h00051b36, 1'b0, 4'd3}, // R3
    '{1'b0, 8'h08, 2'b10, 32'h0,        32'h02000001, 1'b0, 4'd3}, // R3
    '{1'b0, 8'h0E, 2'b00, 32'h0,        32'h00000000, 1'b0, 4'd3}, // R3
    '{1'b0, 8'h3C, 2'b10, 32'h0,        32'h00000100, 1'b0, 4'd3}, // R3
    '{1'b1, 8'h00, 2'b10, 32'hffffffff, 32'h00051b36, 1'b0, 4'd3}, // R3
    '{1'b1, 8'h10, 2'b10, 32'hffffffff, 32'hffffffe1, 1'b1, 4'd4}, // R4
    '{1'b1, 8'h14, 2'b10, 32'hffffffff, 32'hffffff00, 1'b1, 4'd4}, // R4
    '{1'b1, 8'h14, 2'b10, 32'h12345678, 32'h12345600, 1'b1, 4'd4}, // R4
    '{1'b1, 8'h18, 2'b10, 32'hffffffff, 32'h00000000, 1'b1, 4'd5}, // R5
    '{1'b1, 8'h24, 2'b10, 32'hffffffff, 32'h00000000, 1'b1, 4'd5}, // R5
    '{1'b1, 8'h30, 2'b10, 32'hffffffff, 32'hfffff801, 1'b1, 4'd6}, // R6
    '{1'b1, 8'h30, 2'b10, 32'h12345678, 32'h12345000, 1'b1, 4'd6}, // R6
    '{1'b1, 8'h30, 2'b10, 32'h0000c801, 32'h0000c801, 1'b1, 4'd6}, // R6
    '{1'b1, 8'h10, 2'b00, 32'h000000aa, 32'h000000e1, 1'b0, 4'd7}, // R7
    '{1'b1, 8'h14, 2'b01, 32'h0000beef, 32'h00005600, 1'b0, 4'd7}, // R7
    '{1'b0, 8'h14, 2'b10, 32'h0,        32'h12345600, 1'b0, 4'd7}, // R7
    '{1'b1, 8'h04, 2'b01, 32'h00000107, 32'h00000107, 1'b1, 4'd9}, // R9
    '{1'b0, 8'h04, 2'b10, 32'h0,        32'h00000107, 1'b0, 4'd8}, // R8
    '{1'b1, 8'h06, 2'b01, 32'h0000ffff, 32'h00000000, 1'b0, 4'd8}, // R8
    '{1'b1, 8'h03, 2'b10, 32'h00aabb00, 32'h00aabb00, 1'b1, 4'd9}, // R9
    '{1'b1, 8'h0C, 2'b01, 32'h0000ee11, 32'h0000ee11, 1'b0, 4'd8}, // R8
    '{1'b1, 8'h40, 2'b10, 32'hdeadbeef, 32'hdeadbeef, 1'b0, 4'd8}, // R8
    '{1'b0, 8'h41, 2'b01, 32'h0,        32'h0000adbe, 1'b0, 4'd2}, // R2
    '{1'b0, 8'h42, 2'b00, 32'h0,        32'h000000ad, 1'b0, 4'd2}, // R2
    '{1'b1, 8'hFC, 2'b10, 32'h44332211, 32'h44332211, 1'b0, 4'd8}, // R8
    '{1'b0, 8'hFD, 2'b10, 32'h0,        32'h00000022, 1'b0, 4'd2}, // R2
    '{1'b0, 8'hFE, 2'b01, 32'h0,        32'h00004433, 1'b0, 4'd2}, // R2
    '{1'b0, 8'hFF, 2'b01, 32'h0,        32'h00000044, 1'b0, 4'd2}, // R2
    '{1'b1, 8'hFE, 2'b10, 32'haabbccdd, 32'h000000dd, 1'b0, 4'd8}, // R8
    '{1'b0, 8'hFC, 2'b10, 32'h0,        32'hccdd2211, 1'b0, 4'd8}, // R8
    '{1'b0, 8'h40, 2'b11, 32'h0,        32'h000000ef, 1'b0, 4'd2}, // R2
    '{1'b1, 8'h3D, 2'b00, 32'h00000055, 32'h00000001, 1'b0, 4'd3}, // R3
    '{1'b1, 8'h3C, 2'b00, 32'h0000005a, 32'h0000005a, 1'b0, 4'd8}, // R8
    '{1'b1, 8'h28, 2'b10, 32'hffffffff, 32'h00000000, 1'b0, 4'd8}  // R8
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %08h expected %08h", tag, act, exp);
    end
  endtask

  task automatic rd(input logic [7:0] a, input logic [1:0] w);
    wr_en_i = 1'b0; addr_i = a; width_i = w; wdata_i = '0;
    @(negedge clk_i);
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    // R1: reset values
    rd(8'h04, 2'b01); check("R1 command", rdata_o, 32'h0);
    rd(8'h10, 2'b10); check("R1 bar0",    rdata_o, 32'h00000001);
    rd(8'h30, 2'b10); check("R1 rom",     rdata_o, 32'h0);
    rd(8'h40, 2'b10); check("R1 devspec", rdata_o, 32'h0);
    check("R9 idle remap", {31'd0, remap_o}, 32'h0);
    rd(8'h18, 2'b10); check("R5 bar2 reset", rdata_o, 32'h0);

    for (int k = 0; k < NV; k++) begin
      wr_en_i = VEC[k].wr; addr_i = VEC[k].addr;
      width_i = VEC[k].w;  wdata_i = VEC[k].wd;
      @(negedge clk_i);
      check($sformatf("R%0d vec %0d data", VEC[k].req, k), rdata_o, VEC[k].exp);
      check($sformatf("R9 vec %0d remap", k), {31'd0, remap_o}, {31'd0, VEC[k].rmp});
    end

    // R9: remap drops after a single write cycle
    rd(8'h04, 2'b00); check("R9 remap pulse end", {31'd0, remap_o}, 32'h0);

    // R1: reset mid-run clears written state
    rst_ni = 1'b0;
    @(negedge clk_i);
    rst_ni = 1'b1;
    rd(8'h04, 2'b01); check("R1 command after reset", rdata_o, 32'h0);
    rd(8'h14, 2'b10); check("R1 bar1 after reset",    rdata_o, 32'h0);
    rd(8'h30, 2'b10); check("R1 rom after reset",     rdata_o, 32'h0);
    rd(8'h40, 2'b10); check("R1 devspec after reset", rdata_o, 32'h0);
    rd(8'h3C, 2'b00); check("R1 int line after reset", rdata_o, 32'h0);
    done = 1'b1;
    finish_run();
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
    end
  end
endmodule